// File: doc/BRIEF.md
# Supervisory Watchdog Timer

This block watches a host and raises an alarm when the host stops checking in. It counts timer ticks from a 32.768 kHz tick enable and uses one of eight timeout lengths. If the count reaches its end before anything reloads it, the block sets a sticky timeout flag and drives an active-high pulse on its alarm output. The pulse width is selectable: short or long. Software reads and writes one 8-bit control word through a plain write strobe and a read bus.

The host reloads the count in one of two ways: it pulses a clear-command strobe, or, when edge feeding is enabled, it lets either edge of an external event line do it. That event line is synchronized before its edges are detected. After a timeout the block stays halted until software writes the flag back to zero. That write reloads the count.

An optional start-up delay holds off counting for 64 seconds of ticks each time counting is armed. Either a battery-mode input or a power-fail input removes the enable, and software has to set the enable again afterwards. A `TIME_SHIFT` parameter divides every tick count by a power of two, so that a scaled-down instance can be built.

Top module: `wdog_timer`

## Requirements
- R1: After reset the control word reads 0x00 and `wdo` is low. While the enable bit (bit 7) is 0, the timeout flag never sets.
- R2: While `batt_mode` or `pwr_fail` is high, the enable bit is forced to 0 and writes that try to set it have no effect. The bit stays 0 after both inputs return low. `batt_mode` also ends any alarm pulse on the next cycle.
- R3: Bits 2:0 select the timeout in ticks: 0→32, 1→512, 2→2048, 3→4096, 4→32768, 5→524288, 6→1048576, 7→2097152. Each count is shifted right by `TIME_SHIFT`, with a minimum of 1. Expiry comes on the Nth tick after the count is loaded.
- R4: On expiry, the flag (bit 6) and `wdo` rise in the same cycle. The flag stays set until software writes 0 to bit 6. Writing 1 to bit 6 has no effect.
- R5: While the flag is set, counting is halted and `wdo` does not fire again. Clearing the flag while enabled reloads and rearms the count.
- R6: Bit 4 selects the pulse width: 0 gives 4 ticks and 1 gives 4096 ticks, each scaled like R3 with a minimum of 1.
- R7: When bit 5 is set, arming first waits 2097152 ticks (scaled) before the timeout count starts. Arming means enabling, or clearing the flag while enabled.
- R8: `clr_cmd` reloads the running count. If it arrives on the tick that would have expired, the reload wins and nothing fires.
- R9: With `evt_feed_en` high, a rising or falling edge on `evt_in` reloads the count three cycles after the input changes. With `evt_feed_en` low, edges have no effect.
- R10: A write that changes bits 2:0 while counting reloads the count with the new period. A write that keeps the same period does not reload.
- R11: The count only advances on cycles where `tick_en` is high.
- R12: Bit 3 always reads 0, whatever value is written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle 32.768 kHz tick enable |
| batt_mode | input | 1 | Running from backup supply; forces the watchdog off |
| pwr_fail | input | 1 | Main-supply failure indication; clears the enable |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 8 | Control word write value |
| reg_rdata | output | 8 | Control word read value |
| clr_cmd | input | 1 | Clear-command strobe that reloads the count |
| evt_in | input | 1 | Asynchronous external event line |
| evt_feed_en | input | 1 | Allows `evt_in` edges to reload the count |
| wdo | output | 1 | Active-high timeout pulse |

## Verification
A reload request can land on the same cycle as the final tick, so a clear and an expiry can coincide. The bench enables a short period and lines `clr_cmd` up with the cycle that would expire. It then expects the flag and `wdo` to stay low and the next expiry to come one full period later, at twice the period from the enable. It also times clears that arrive earlier, and edge-feed reloads on both edges, against arithmetic cycle counts.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   localparam int unsigned WD_DELAY_RAW = 2097152;
   localparam int unsigned WD_PW_SHORT_RAW = 4;
   localparam int unsigned WD_PW_LONG_RAW = 4096;

   function automatic int unsigned wd_scaled(input int unsigned raw, input int unsigned sh);
      int unsigned v;
      v = raw >> sh;
      return (v == 0) ? 1 : v;
   endfunction

   function automatic int unsigned wd_period_raw(input logic [2:0] code);
      int unsigned r;
      case (code)
         3'd0:    r = 32;
         3'd1:    r = 512;
         3'd2:    r = 2048;
         3'd3:    r = 4096;
         3'd4:    r = 32768;
         3'd5:    r = 524288;
         3'd6:    r = 1048576;
         default: r = 2097152;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/wdog_edge_sync.sv
module wdog_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic edge_o
);
   logic [STAGES:0] sh;

   generate
      for (genvar i = 0; i <= STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sh[0] <= 1'b0;
               else        sh[0] <= din;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sh[i] <= 1'b0;
               else        sh[i] <= sh[i-1];
         end
      end
   endgenerate

   assign edge_o = sh[STAGES-1] ^ sh[STAGES];
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
   parameter int unsigned W_SHORT = 4,
   parameter int unsigned W_LONG  = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic start,
   input  logic wide,
   input  logic kill,
   output logic active
);
   localparam int unsigned WMAX = (W_LONG > W_SHORT) ? W_LONG : W_SHORT;
   localparam int PW = $clog2(WMAX + 1);

   logic [PW-1:0] pc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     pc <= '0;
      else if (kill)                  pc <= '0;
      else if (start)                 pc <= wide ? PW'(W_LONG) : PW'(W_SHORT);
      else if (tick && pc != '0)      pc <= pc - PW'(1);
   end

   assign active = (pc != '0);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
   parameter int TIME_SHIFT      = 0,
   parameter int SYNC_STAGES     = 2,
   parameter bit HAS_START_DELAY = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_en,
   input  logic       batt_mode,
   input  logic       pwr_fail,
   input  logic       reg_wr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   input  logic       clr_cmd,
   input  logic       evt_in,
   input  logic       evt_feed_en,
   output logic       wdo
);
   import wdog_pkg::*;

   localparam int unsigned MAX_TICKS = wd_scaled(wd_period_raw(3'd7), TIME_SHIFT);
   localparam int unsigned DLY_TICKS = wd_scaled(WD_DELAY_RAW, TIME_SHIFT);
   localparam int unsigned PW_SHORT  = wd_scaled(WD_PW_SHORT_RAW, TIME_SHIFT);
   localparam int unsigned PW_LONG   = wd_scaled(WD_PW_LONG_RAW, TIME_SHIFT);
   localparam int CNT_W = $clog2(MAX_TICKS + 1);
   localparam int DLY_W = $clog2(DLY_TICKS + 1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("wdog_timer: SYNC_STAGES must be at least 2");
      end
      if (TIME_SHIFT < 0 || TIME_SHIFT > 16) begin : g_bad_shift
         $error("wdog_timer: TIME_SHIFT out of range 0..16");
      end
   endgenerate

   // control fields
   logic       en_q, flag_q, dly_q, pw_q;
   logic [2:0] per_q;
   // counting state
   logic             delaying_q;
   logic [CNT_W-1:0] cnt_q;
   logic [DLY_W-1:0] dcnt_q;

   logic evt_edge;
   logic blk, kick, running, expire;
   logic en_n, flag_n, dly_n, pw_n, flag_clr, per_chg, arm, dly_wbit;
   logic [2:0] per_n;
   logic [CNT_W-1:0] per_ticks;

   wire unused_rsv = reg_wdata[3];

   generate
      if (HAS_START_DELAY) begin : g_dly_on
         assign dly_wbit = reg_wdata[5];
      end else begin : g_dly_off
         wire unused_dly = reg_wdata[5];
         assign dly_wbit = 1'b0;
      end
   endgenerate

   wdog_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (evt_in),
      .edge_o (evt_edge)
   );

   always_comb begin
      blk      = batt_mode | pwr_fail;
      kick     = clr_cmd | (evt_feed_en & evt_edge);
      running  = en_q & ~flag_q & ~delaying_q;
      expire   = running & tick_en & (cnt_q == CNT_W'(1)) & ~kick & ~blk;
      per_n    = reg_wr ? reg_wdata[2:0] : per_q;
      pw_n     = reg_wr ? reg_wdata[4]   : pw_q;
      dly_n    = reg_wr ? dly_wbit       : dly_q;
      en_n     = blk ? 1'b0 : (reg_wr ? reg_wdata[7] : en_q);
      flag_clr = reg_wr & ~reg_wdata[6] & flag_q;
      flag_n   = (flag_q & ~flag_clr) | expire;
      per_chg  = reg_wr & (reg_wdata[2:0] != per_q);
      arm      = en_n & ~flag_n & (~en_q | flag_clr);
      per_ticks = CNT_W'(wd_scaled(wd_period_raw(per_n), TIME_SHIFT));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q       <= 1'b0;
         flag_q     <= 1'b0;
         dly_q      <= 1'b0;
         pw_q       <= 1'b0;
         per_q      <= 3'd0;
         delaying_q <= 1'b0;
         cnt_q      <= '0;
         dcnt_q     <= '0;
      end else begin
         en_q   <= en_n;
         flag_q <= flag_n;
         dly_q  <= dly_n;
         pw_q   <= pw_n;
         per_q  <= per_n;
         if (!en_n || flag_n) begin
            delaying_q <= 1'b0;
         end else if (arm) begin
            if (dly_n) begin
               delaying_q <= 1'b1;
               dcnt_q     <= DLY_W'(DLY_TICKS);
            end else begin
               cnt_q <= per_ticks;
            end
         end else if (delaying_q) begin
            if (tick_en) begin
               if (dcnt_q == DLY_W'(1)) begin
                  delaying_q <= 1'b0;
                  cnt_q      <= per_ticks;
               end else begin
                  dcnt_q <= dcnt_q - DLY_W'(1);
               end
            end
         end else if (kick || per_chg) begin
            cnt_q <= per_ticks;
         end else if (tick_en) begin
            cnt_q <= cnt_q - CNT_W'(1);
         end
      end
   end

   wdog_pulse #(.W_SHORT(PW_SHORT), .W_LONG(PW_LONG)) u_pulse (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick_en),
      .start  (expire),
      .wide   (pw_q),
      .kill   (batt_mode),
      .active (wdo)
   );

   assign reg_rdata = {en_q, flag_q, dly_q, pw_q, 1'b0, per_q};
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       batt_mode,
   input logic       pwr_fail,
   input logic       reg_wr,
   input logic [7:0] reg_wdata,
   input logic [7:0] reg_rdata,
   input logic       clr_cmd,
   input logic       wdo
);
   assert_supply_drops_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (batt_mode || pwr_fail) |=> !reg_rdata[7]);

   assert_battery_ends_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      batt_mode |=> !wdo);

   assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[6] && !(reg_wr && !reg_wdata[6])) |=> reg_rdata[6]);

   assert_pulse_with_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdo) |-> $rose(reg_rdata[6]));

   assert_clear_blocks_expiry_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_cmd && !reg_rdata[6]) |=> !reg_rdata[6]);

   assert_idle_never_flags_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_rdata[7] && !reg_rdata[6]) |=> !reg_rdata[6]);
endmodule

bind wdog_timer wdog_timer_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .batt_mode (batt_mode),
   .pwr_fail  (pwr_fail),
   .reg_wr    (reg_wr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .clr_cmd   (clr_cmd),
   .wdo       (wdo)
);

// File: tb/wdog_timer_bench.sv
`timescale 1ns/1ps
module wdog_timer_bench;
   localparam int SH = 7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b1;
   logic       batt_mode = 1'b0;
   logic       pwr_fail = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       clr_cmd = 1'b0;
   logic       evt_in = 1'b0;
   logic       evt_feed_en = 1'b0;
   logic       wdo;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   wdog_timer #(.TIME_SHIFT(SH), .SYNC_STAGES(2), .HAS_START_DELAY(1'b1)) u_wdog_timer (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .batt_mode(batt_mode),
      .pwr_fail(pwr_fail), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .clr_cmd(clr_cmd), .evt_in(evt_in),
      .evt_feed_en(evt_feed_en), .wdo(wdo)
   );

   function automatic int scl(input int raw);
      int v;
      v = raw >> SH;
      return (v < 1) ? 1 : v;
   endfunction

   function automatic int exp_period(input int code);
      int lg;
      case (code)
         0: lg = 5;  1: lg = 9;  2: lg = 11; 3: lg = 12;
         4: lg = 15; 5: lg = 19; 6: lg = 20; default: lg = 21;
      endcase
      return scl(1 << lg);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] v);
      @(negedge clk);
      reg_wr = 1'b1;
      reg_wdata = v;
      @(posedge clk);
      #1;
      reg_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   // counts cycles until wdo rises; optional clear strobe / event toggle at given counts
   task automatic measure(input int clr_at, input int evt_at, input int limit, output int cyc);
      cyc = 0;
      while (!wdo && cyc < limit) begin
         @(posedge clk);
         #1;
         cyc++;
         clr_cmd = 1'b0;
         if (cyc == clr_at) clr_cmd = 1'b1;
         if (cyc == evt_at) evt_in = ~evt_in;
      end
      clr_cmd = 1'b0;
   endtask

   task automatic width(output int cyc);
      cyc = 0;
      while (wdo && cyc < 10000) begin
         @(posedge clk);
         #1;
         cyc++;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int c, n, w;
      logic [7:0] v;
      idle(4);
      rst_n = 1'b1;
      idle(2);
      chk(reg_rdata == 8'h00, "R1 reset word", reg_rdata, 0);
      chk(wdo == 1'b0, "R1 reset wdo", wdo, 0);

      // sweep every period code, alternating pulse width
      for (int code = 0; code < 8; code++) begin
         v = {1'b1, 1'b0, 1'b0, code[0], 1'b0, code[2:0]};
         n = exp_period(code);
         w = code[0] ? scl(4096) : scl(4);
         wr(8'h00);
         wr(v);
         measure(-1, -1, n + 50, c);
         chk(c == n, "R3 timeout length", c, n);
         chk(reg_rdata[6] == 1'b1, "R4 flag with output", reg_rdata[6], 1);
         width(c);
         chk(c == w, "R6 pulse width", c, w);
         idle(((n < 200) ? n : 200) + 5);
         chk(wdo == 1'b0 && reg_rdata[6] == 1'b1, "R5 halted while flagged",
             {wdo, reg_rdata[6]}, 1);
         if (code <= 5) begin
            wr(v);
            chk(reg_rdata[6] == 1'b0, "R5 flag cleared by write", reg_rdata[6], 0);
            measure(-1, -1, n + 50, c);
            chk(c == n, "R5 rearm after clear", c, n);
            width(c);
         end
      end

      // R10 period change reloads, same period does not
      wr(8'h00); wr(8'h83); idle(10); wr(8'h82);
      measure(-1, -1, 200, c);
      chk(c == exp_period(2), "R10 reload on new period", c, exp_period(2));
      width(c);
      wr(8'h00); wr(8'h82); idle(10); wr(8'h82);
      measure(-1, -1, 200, c);
      chk(c == exp_period(2) - 11, "R10 no reload on same period", c, exp_period(2) - 11);
      width(c);

      // R8 clear command, early and coinciding with final tick
      n = exp_period(2);
      wr(8'h00); wr(8'h82);
      measure(5, -1, 200, c);
      chk(c == 5 + 1 + n, "R8 clear reload", c, 6 + n);
      width(c);
      wr(8'h00); wr(8'h82);
      measure(n - 1, -1, 200, c);
      chk(c == 2 * n, "R8 clear on final tick wins", c, 2 * n);
      width(c);

      // R9 edge feed: rising, falling, then disabled
      evt_feed_en = 1'b1;
      wr(8'h00); wr(8'h82);
      measure(-1, 6, 200, c);
      chk(c == 6 + 3 + n, "R9 rising edge feed", c, 9 + n);
      width(c);
      wr(8'h00); wr(8'h82);
      measure(-1, 6, 200, c);
      chk(c == 6 + 3 + n, "R9 falling edge feed", c, 9 + n);
      width(c);
      evt_feed_en = 1'b0;
      wr(8'h00); wr(8'h82);
      measure(-1, 6, 200, c);
      chk(c == n, "R9 feed disabled ignored", c, n);
      width(c);

      // R11 count frozen without ticks
      tick_en = 1'b0;
      wr(8'h00); wr(8'h81);
      idle(20);
      chk(wdo == 1'b0 && reg_rdata[6] == 1'b0, "R11 frozen without tick",
          {wdo, reg_rdata[6]}, 0);
      tick_en = 1'b1;
      measure(-1, -1, 200, c);
      chk(c == exp_period(1), "R11 resumes on ticks", c, exp_period(1));
      width(c);

      // R7 start-up delay
      wr(8'h00); wr(8'hA0);
      measure(-1, -1, 20000, c);
      chk(c == scl(2097152) + exp_period(0), "R7 start delay", c, scl(2097152) + exp_period(0));
      width(c);

      // R2 supply loss
      wr(8'h00); wr(8'h87);
      @(negedge clk); batt_mode = 1'b1;
      @(posedge clk); #1; batt_mode = 1'b0;
      chk(reg_rdata[7] == 1'b0, "R2 battery clears enable", reg_rdata[7], 0);
      pwr_fail = 1'b1;
      wr(8'h87);
      chk(reg_rdata[7] == 1'b0, "R2 enable write blocked", reg_rdata[7], 0);
      pwr_fail = 1'b0;
      idle(3);
      chk(reg_rdata[7] == 1'b0, "R2 enable stays clear", reg_rdata[7], 0);
      wr(8'h00); wr(8'h90);
      measure(-1, -1, 50, c);
      @(negedge clk); batt_mode = 1'b1;
      @(posedge clk); #1; batt_mode = 1'b0;
      chk(wdo == 1'b0, "R2 battery ends pulse", wdo, 0);

      // R4 / R12 write-one to flag and reserved bit ignored
      wr(8'h00); wr(8'hFF);
      chk(reg_rdata == 8'hB7, "R4 R12 ignored bits", reg_rdata, 8'hB7);
      wr(8'h00);
      chk(reg_rdata == 8'h00, "R1 disabled word", reg_rdata, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule